// File: doc/BRIEF.md
# Predicated Floating-Point Immediate Vector Copy Unit

This block takes one 32-bit instruction word that asks for a floating-point constant to be written into a vector register under predicate control. It checks the fixed opcode fields and reads the element-size field. The 8-bit packed constant is widened to a half, single or double precision value. That value is copied into every element whose governing predicate bit is set. Elements whose predicate bit is clear keep the contents they already had.

The surrounding pipeline supplies three things: the instruction with a valid strobe, the current contents of the destination vector, and the contents of the predicate register that the instruction names. One cycle later the block returns the merged vector and a write enable. It also returns the destination and predicate register numbers taken from the word, and a flag for the reserved size encoding. The register files, the delivery of exceptions and any checks that pair this instruction with a neighbouring one belong to the caller. The vector length is a parameter and must be a multiple of 128 bits. The predicate holds one bit per vector byte.

Top module: `fimm_copy_unit`

## Requirements
- R1: A word is recognised only when bits [31:24] equal 8'b00000101, bits [21:20] equal 2'b01 and bits [15:13] equal 3'b110. In a recognised word, bits [23:22] are the size code and bits [12:5] are the packed constant.
- R2: A recognised word with size code 00 sets `out_undef` one cycle later, keeps `out_wen` low, and returns the old destination vector unchanged.
- R3: Size code 01 gives 16-bit elements, 10 gives 32-bit elements and 11 gives 64-bit elements. The vector holds VLEN divided by that width elements, with element e occupying bits [e*W +: W].
- R4: In a recognised word with a nonzero size code, every element whose governing predicate bit is 1 becomes the widened constant.
- R5: Every element whose governing predicate bit is 0 keeps its prior destination value. An all-zero predicate returns the destination vector unchanged.
- R6: The packed constant c[7:0] widens as follows. The sign is c[7]. The exponent is ~c[6], then c[6] repeated (E-3) times, then c[5:4]. The fraction is c[3:0] followed by zeros. E is 5, 8 or 11 and the fraction width is 10, 23 or 52 for the three sizes. The result is the value ±(16+c[3:0])/16 × 2^r, where r is c[5:4]-3 when c[6] is 1 and c[5:4]+1 when c[6] is 0.
- R7: The governing predicate bit for element e is predicate bit e×(W/8). The other predicate bits are ignored.
- R8: Each input accepted with `in_valid` high gives `out_valid` high exactly one cycle later. Without a valid input, `out_valid`, `out_wen` and `out_undef` are low the next cycle, and `out_vec`, `out_zd` and `out_pg` hold their previous values.
- R9: An accepted word that is not recognised keeps `out_wen` and `out_undef` low and returns the destination vector unchanged.
- R10: For every accepted word, `out_zd` carries bits [4:0] and `out_pg` carries bits [19:16] one cycle later.
- R11: While `rst_n` is low at a rising clock edge, every output becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| dst_vec | input | VLEN | Current destination vector contents |
| pred | input | VLEN/8 | Contents of the governing predicate register |
| out_valid | output | 1 | Result of the input from the previous cycle |
| out_wen | output | 1 | Write the result back to the destination register |
| out_undef | output | 1 | Recognised word with the reserved size code |
| out_vec | output | VLEN | Merged result vector |
| out_zd | output | 5 | Destination register number |
| out_pg | output | 4 | Predicate register number |

## Verification
The bench builds the unit with VLEN = 384. That length is a legal multiple of 128 but not a power of two. The vector then holds 24 halves, 12 singles and 6 doubles, so the count of elements in each merge is not a power of two either. At this length the uppermost elements and the uppermost predicate bits fall at indices that a power-of-two vector would never exercise. The bench sweeps all 256 constants for every size against an arithmetic reconstruction of the value, which reaches the extremes of the exponent and both signs.

// File: rtl/fimm_pkg.sv
// Package fimm_pkg
// Purpose : shared encodings for the predicated immediate copy unit.
// Assumes : the fixed opcode fields are those of the 32-bit word layout
//           decoded in fimm_decode.
package fimm_pkg;

    typedef enum logic [1:0] {
        SZ_RSVD   = 2'b00,
        SZ_HALF   = 2'b01,
        SZ_SINGLE = 2'b10,
        SZ_DOUBLE = 2'b11
    } esize_e;

    typedef struct packed {
        logic       hit;    // fixed fields match
        esize_e     size;   // element size code
        logic [3:0] pg;     // predicate register number
        logic [7:0] imm;    // packed constant
        logic [4:0] zd;     // destination register number
    } fields_t;

    localparam logic [7:0] OPC_HI  = 8'b0000_0101;
    localparam logic [1:0] OPC_MID = 2'b01;
    localparam logic [2:0] OPC_LO  = 3'b110;

endpackage

// File: rtl/fimm_decode.sv
// Module  : fimm_decode
// Purpose : splits the instruction word into its fields and flags whether
//           the fixed opcode bits match.
// Assumes : purely combinational; the caller qualifies the result with valid.
module fimm_decode
    import fimm_pkg::*;
(
    input  logic [31:0] instr,
    output fields_t     fields
);

    // Field extraction and opcode comparison.
    always_comb begin
        fields.hit  = (instr[31:24] == OPC_HI) &&
                      (instr[21:20] == OPC_MID) &&
                      (instr[15:13] == OPC_LO);
        fields.size = esize_e'(instr[23:22]);
        fields.pg   = instr[19:16];
        fields.imm  = instr[12:5];
        fields.zd   = instr[4:0];
    end

endmodule

// File: rtl/fimm_expand.sv
// Module  : fimm_expand
// Purpose : widens the 8-bit packed constant into one IEEE format of
//           EXPW exponent bits and FRACW fraction bits.
// Assumes : EXPW >= 3 and FRACW >= 4; combinational.
module fimm_expand #(
    parameter int EXPW  = 5,
    parameter int FRACW = 10,
    localparam int W    = 1 + EXPW + FRACW
) (
    input  logic [7:0]   imm,
    output logic [W-1:0] value
);

    localparam int REP = EXPW - 3;
    localparam int PAD = FRACW - 4;

    // Sign, replicated exponent and zero-padded fraction.
    always_comb begin
        value = {imm[7], ~imm[6], {REP{imm[6]}}, imm[5:4],
                 imm[3:0], {PAD{1'b0}}};
    end

endmodule

// File: rtl/fimm_merge.sv
// Module  : fimm_merge
// Purpose : for one element width, writes VALUE into each element whose
//           governing predicate bit is set and keeps the others.
// Assumes : VLEN is a multiple of ESIZE, ESIZE is a multiple of 8, and the
//           predicate has one bit per byte.
module fimm_merge #(
    parameter int VLEN  = 256,
    parameter int ESIZE = 16,
    localparam int PLEN = VLEN / 8
) (
    input  logic [VLEN-1:0]  dst,
    input  logic [PLEN-1:0]  pred,
    input  logic [ESIZE-1:0] value,
    output logic [VLEN-1:0]  merged
);

    localparam int NELEM  = VLEN / ESIZE;
    localparam int PSTEP  = ESIZE / 8;

    // Only every PSTEP-th predicate bit governs; the rest are ignored.
    logic unused_pred;
    assign unused_pred = ^pred;

    for (genvar e = 0; e < NELEM; e++) begin : g_elem
        // Per-element select between the constant and the old contents.
        assign merged[e*ESIZE +: ESIZE] = pred[e*PSTEP] ? value
                                                        : dst[e*ESIZE +: ESIZE];
    end

endmodule

// File: rtl/fimm_copy_unit.sv
// Module  : fimm_copy_unit
// Purpose : decodes a predicated floating-point immediate copy, widens the
//           constant to the coded element size, merges it into the
//           destination vector and registers the result with one cycle
//           of latency.
// Assumes : VLEN is a multiple of 128; pred has one bit per vector byte;
//           synchronous active-low reset.
module fimm_copy_unit
    import fimm_pkg::*;
#(
    parameter int VLEN  = 256,
    localparam int PLEN = VLEN / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [VLEN-1:0] dst_vec,
    input  logic [PLEN-1:0] pred,
    output logic            out_valid,
    output logic            out_wen,
    output logic            out_undef,
    output logic [VLEN-1:0] out_vec,
    output logic [4:0]      out_zd,
    output logic [3:0]      out_pg
);

    fields_t         fld;
    logic [15:0]     val_h;
    logic [31:0]     val_s;
    logic [63:0]     val_d;
    logic [VLEN-1:0] mrg_h;
    logic [VLEN-1:0] mrg_s;
    logic [VLEN-1:0] mrg_d;
    logic [VLEN-1:0] mrg_sel;
    logic            wr_ok;
    logic            rsvd;

    fimm_decode u_dec (.instr(instr), .fields(fld));

    fimm_expand #(.EXPW(5),  .FRACW(10)) u_exp_h (.imm(fld.imm), .value(val_h));
    fimm_expand #(.EXPW(8),  .FRACW(23)) u_exp_s (.imm(fld.imm), .value(val_s));
    fimm_expand #(.EXPW(11), .FRACW(52)) u_exp_d (.imm(fld.imm), .value(val_d));

    fimm_merge #(.VLEN(VLEN), .ESIZE(16)) u_mrg_h
        (.dst(dst_vec), .pred(pred), .value(val_h), .merged(mrg_h));
    fimm_merge #(.VLEN(VLEN), .ESIZE(32)) u_mrg_s
        (.dst(dst_vec), .pred(pred), .value(val_s), .merged(mrg_s));
    fimm_merge #(.VLEN(VLEN), .ESIZE(64)) u_mrg_d
        (.dst(dst_vec), .pred(pred), .value(val_d), .merged(mrg_d));

    // Classify the word and pick the merge for its element size.
    always_comb begin
        rsvd  = fld.hit && (fld.size == SZ_RSVD);
        wr_ok = fld.hit && (fld.size != SZ_RSVD);
        unique case (fld.size)
            SZ_HALF:   mrg_sel = mrg_h;
            SZ_SINGLE: mrg_sel = mrg_s;
            SZ_DOUBLE: mrg_sel = mrg_d;
            default:   mrg_sel = dst_vec;
        endcase
    end

    // Output register: strobes follow valid, data loads only on valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_wen   <= 1'b0;
            out_undef <= 1'b0;
            out_vec   <= '0;
            out_zd    <= '0;
            out_pg    <= '0;
        end else begin
            out_valid <= in_valid;
            out_wen   <= in_valid && wr_ok;
            out_undef <= in_valid && rsvd;
            if (in_valid) begin
                out_vec <= wr_ok ? mrg_sel : dst_vec;
                out_zd  <= fld.zd;
                out_pg  <= fld.pg;
            end
        end
    end

endmodule

// File: rtl/fimm_copy_chk.sv
// Module  : fimm_copy_chk
// Purpose : temporal properties of fimm_copy_unit, attached by bind.
// Assumes : sampled on the unit's clock; disabled while reset is low.
module fimm_copy_chk #(
    parameter int VLEN  = 256,
    localparam int PLEN = VLEN / 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [31:0]     instr,
    input logic [VLEN-1:0] dst_vec,
    input logic [PLEN-1:0] pred,
    input logic            out_valid,
    input logic            out_wen,
    input logic            out_undef,
    input logic [VLEN-1:0] out_vec,
    input logic [4:0]      out_zd,
    input logic [3:0]      out_pg
);

    p_undef_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> !out_wen);

    p_rsvd_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:24] == 8'h05 && instr[21:20] == 2'b01 &&
         instr[15:13] == 3'b110 && instr[23:22] == 2'b00) |=> out_undef);

    p_empty_pred_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred == '0) |=> (out_vec == $past(dst_vec)));

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wen && !out_undef && $stable(out_vec)));

    p_nomatch_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:24] != 8'h05) |=>
            (!out_wen && !out_undef && out_vec == $past(dst_vec)));

    p_field_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_zd == $past(instr[4:0]) && out_pg == $past(instr[19:16])));

endmodule

bind fimm_copy_unit fimm_copy_chk #(.VLEN(VLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .dst_vec(dst_vec), .pred(pred), .out_valid(out_valid),
    .out_wen(out_wen), .out_undef(out_undef), .out_vec(out_vec),
    .out_zd(out_zd), .out_pg(out_pg)
);

// File: tb/sim_fimm_copy_unit.sv
`timescale 1ns/1ps
module sim_fimm_copy_unit;

    localparam int VLEN = 384;
    localparam int PLEN = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [31:0]     instr = '0;
    logic [VLEN-1:0] dst_vec = '0;
    logic [PLEN-1:0] pred = '0;
    logic            out_valid, out_wen, out_undef;
    logic [VLEN-1:0] out_vec;
    logic [4:0]      out_zd;
    logic [3:0]      out_pg;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    // expected outputs for the next compare
    logic            e_valid = 0, e_wen = 0, e_undef = 0;
    logic [VLEN-1:0] e_vec = '0;
    logic [4:0]      e_zd = '0;
    logic [3:0]      e_pg = '0;
    string           e_tag = "R11";

    fimm_copy_unit #(.VLEN(VLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .dst_vec(dst_vec), .pred(pred), .out_valid(out_valid),
        .out_wen(out_wen), .out_undef(out_undef), .out_vec(out_vec),
        .out_zd(out_zd), .out_pg(out_pg)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic logic [VLEN-1:0] rnd_vec();
        logic [VLEN-1:0] v;
        for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [PLEN-1:0] rnd_pred();
        logic [PLEN-1:0] p;
        for (int i = 0; i < PLEN; i++) p[i] = 1'($urandom);
        return p;
    endfunction

    function automatic logic [31:0] mk(input logic [1:0] sz, input logic [3:0] pg,
                                       input logic [7:0] c, input logic [4:0] zd);
        return {8'b0000_0101, sz, 2'b01, pg, 3'b110, c, zd};
    endfunction

    // arithmetic reconstruction of +-(16+m)/16 * 2^r in an IEEE format
    function automatic logic [63:0] widen(input logic [7:0] c, input int esize);
        int ew, fw, bias, r;
        logic [63:0] v;
        ew   = (esize == 16) ? 5 : (esize == 32) ? 8 : 11;
        fw   = esize - 1 - ew;
        bias = (1 << (ew - 1)) - 1;
        r    = c[6] ? int'(c[5:4]) - 3 : int'(c[5:4]) + 1;
        v    = (64'(c[7]) << (esize - 1)) | (64'(r + bias) << fw)
             | (64'(c[3:0]) << (fw - 4));
        return v;
    endfunction

    task automatic chk1(input string what, input logic [VLEN-1:0] act,
                        input logic [VLEN-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", e_tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk1("out_valid", VLEN'(out_valid), VLEN'(e_valid));
        chk1("out_wen",   VLEN'(out_wen),   VLEN'(e_wen));
        chk1("out_undef", VLEN'(out_undef), VLEN'(e_undef));
        chk1("out_vec",   out_vec,          e_vec);
        chk1("out_zd",    VLEN'(out_zd),    VLEN'(e_zd));
        chk1("out_pg",    VLEN'(out_pg),    VLEN'(e_pg));
    endtask

    // one cycle: check the previous expectation, drive, predict
    task automatic step(input logic rst, input logic v, input logic [31:0] w,
                        input logic [VLEN-1:0] d, input logic [PLEN-1:0] p,
                        input string tag);
        logic hit;
        logic [1:0] sz;
        int esize;
        logic [63:0] cv;
        logic [VLEN-1:0] m;
        @(negedge clk);
        compare();
        rst_n = rst; in_valid = v; instr = w; dst_vec = d; pred = p;
        e_tag = tag;
        if (!rst) begin
            e_valid = 0; e_wen = 0; e_undef = 0;
            e_vec = '0; e_zd = '0; e_pg = '0;
            return;
        end
        hit = (w[31:24] == 8'h05) && (w[21:20] == 2'b01) && (w[15:13] == 3'b110);
        sz  = w[23:22];
        e_valid = v;
        e_wen   = v && hit && (sz != 2'b00);
        e_undef = v && hit && (sz == 2'b00);
        if (v) begin
            e_zd = w[4:0];
            e_pg = w[19:16];
            m = d;
            if (e_wen) begin
                esize = 8 << sz;
                cv = widen(w[12:5], esize);
                for (int b = 0; b < VLEN; b++)
                    if (p[(b / esize) * (esize / 8)]) m[b] = cv[b % esize];
            end
            e_vec = m;
        end
    endtask

    initial begin
        // R11: reset state
        step(0, 1, mk(2'b01, 4'd3, 8'h70, 5'd9), rnd_vec(), '1, "R11");
        step(0, 0, '0, '0, '0, "R11");
        // R4 R6 R7 R3: every constant at every size, random predicate
        for (int s = 1; s < 4; s++)
            for (int c = 0; c < 256; c++)
                step(1, 1, mk(2'(s), 4'($urandom), 8'(c), 5'($urandom)),
                     rnd_vec(), rnd_pred(), "R6");
        // R4: full predicate, each size
        for (int s = 1; s < 4; s++)
            step(1, 1, mk(2'(s), 4'd15, 8'h00, 5'd31), rnd_vec(), '1, "R4");
        // R5: empty predicate keeps destination
        for (int s = 1; s < 4; s++)
            step(1, 1, mk(2'(s), 4'd0, 8'hFF, 5'd0), rnd_vec(), '0, "R5");
        // R7: only odd predicate bits set, no element is governed by them
        for (int s = 1; s < 4; s++)
            step(1, 1, mk(2'(s), 4'd5, 8'h3C, 5'd7), rnd_vec(),
                 {(PLEN/2){2'b10}}, "R7");
        // R3: only the top predicate bit of each element width
        step(1, 1, mk(2'b11, 4'd1, 8'h8F, 5'd2), rnd_vec(), PLEN'(1) << (PLEN - 8), "R3");
        step(1, 1, mk(2'b01, 4'd1, 8'h8F, 5'd2), rnd_vec(), PLEN'(1) << (PLEN - 2), "R3");
        // R2: reserved size
        for (int i = 0; i < 4; i++)
            step(1, 1, mk(2'b00, 4'($urandom), 8'($urandom), 5'($urandom)),
                 rnd_vec(), rnd_pred(), "R2");
        // R1 R9: each fixed field disturbed
        for (int i = 0; i < 8; i++)
            step(1, 1, mk(2'b10, 4'd2, 8'h55, 5'd4) ^ (32'h1 << (24 + i)),
                 rnd_vec(), '1, "R9");
        step(1, 1, mk(2'b10, 4'd2, 8'h55, 5'd4) ^ 32'h0010_0000, rnd_vec(), '1, "R1");
        step(1, 1, mk(2'b10, 4'd2, 8'h55, 5'd4) ^ 32'h0020_0000, rnd_vec(), '1, "R1");
        step(1, 1, mk(2'b10, 4'd2, 8'h55, 5'd4) ^ 32'h0000_2000, rnd_vec(), '1, "R1");
        step(1, 1, mk(2'b10, 4'd2, 8'h55, 5'd4) ^ 32'h0000_8000, rnd_vec(), '1, "R1");
        // R8 R10: gaps hold data, strobes drop
        step(1, 1, mk(2'b01, 4'd11, 8'h12, 5'd22), rnd_vec(), rnd_pred(), "R10");
        step(1, 0, mk(2'b10, 4'd4, 8'h34, 5'd1), rnd_vec(), rnd_pred(), "R8");
        step(1, 0, '1, rnd_vec(), '1, "R8");
        step(1, 1, mk(2'b11, 4'd6, 8'h99, 5'd30), rnd_vec(), rnd_pred(), "R10");
        // R11: reset again in mid-stream
        step(0, 1, mk(2'b11, 4'd6, 8'h99, 5'd30), rnd_vec(), '1, "R11");
        step(1, 0, '0, '0, '0, "R8");
        step(1, 0, '0, '0, '0, "R8");
        @(negedge clk);
        compare();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule